// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the host-facing register file of a simple keyboard controller. The host reaches it through a byte-wide read/write port. A status byte reports the state of the controller: whether a key code waits for the host, whether a host byte is still pending, and whether an overrun happened. The same address also takes command bytes. A data byte returns the held key code on a read. On a write, it carries LED state after a set-LEDs command.

On the device side, a one-cycle strobe delivers each received key code. The code is held until the host reads the data byte. A level output follows the output-buffer-full flag and can be used as an interrupt. A parameter chooses the address map. In the default map, the data register is at 0x60 and the status/command register is at 0x64. In the word-aligned memory map, status is at offset 0 and data is at offset 4.

Top module: `kbc_regif`

## Requirements
- R1: The status byte is laid out as follows, from bit 7 down to bit 0:
  - bit 7: parity error, always 0.
  - bit 6: overrun/timeout.
  - bit 5: auxiliary buffer, always 0.
  - bit 4: lock, 1 while the keyboard is disabled.
  - bit 3: set when the last accepted host byte was a command.
  - bit 2: system flag, set by a self-test.
  - bit 1: input-buffer full.
  - bit 0: output-buffer full.
  After reset the status byte reads 0x10 and the LED output is 0.
- R2: With MEM_MAPPED=0, address 0x60 selects data and address 0x64 selects status/command. With MEM_MAPPED=1, offset 0 selects status/command and offset 4 selects data. A read of any other address returns 0x00, and a write to any other address has no effect.
- R3: While the keyboard is enabled and the output buffer is empty, a device strobe stores its code and sets output-buffer full on the next clock edge. A later data read returns that code.
- R4: A host read is returned on host_rdata one clock after the read cycle. A data read clears output-buffer full at that same edge.
- R5: A host write sets input-buffer full at the next edge. The byte is acted on at the following edge, and input-buffer full clears one edge after that. A write that arrives while input-buffer full is set is discarded.
- R6: Command 0xAA places 0x55 in the data register and sets output-buffer full and the system flag.
- R7: Command 0xAE enables the keyboard. Until then, device strobes are dropped and output-buffer full stays 0.
- R8: A device strobe that arrives while output-buffer full is set sets the timeout bit and is discarded. The held code is unchanged. A status read clears the timeout bit.
- R9: After command 0xED, the next data write drives its low 3 bits onto led_state. In all other cases a data write leaves led_state unchanged, including when any other command arrives in between.
- R10: obf_irq equals the output-buffer-full status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (8) | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| dev_valid | input | 1 | One-cycle strobe for a received key code |
| dev_code | input | 8 | Received key code |
| led_state | output | LED_W (3) | LED state from the set-LEDs sequence |
| obf_irq | output | 1 | Output-buffer-full level |

## Verification
Every result in this block lands on a fixed edge, counted from the edge that samples the stimulus:
- Read data appears on host_rdata one edge after the read cycle.
- A stored key code, a self-test response and a cleared or set flag become visible right after the edge that samples the strobe.
- A command or LED update takes effect two edges after the write.
- Input-buffer full drops three edges after the write.

The bench drives each access on a falling edge and samples on the next falling edge. For the input-buffer sequence, it reads status back to back, so each read captures the flag at one known edge. Table entries are separated by enough idle cycles that a single entry's effects are complete before the next one.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] CMD_SELFTEST = 8'hAA;
  localparam logic [7:0] CMD_KBD_ON   = 8'hAE;
  localparam logic [7:0] CMD_SET_LED  = 8'hED;
  localparam logic [7:0] SELFTEST_ACK = 8'h55;

  // status bit positions (host software decodes these)
  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_SYS  = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_LOCK = 4;
  localparam int ST_AUX  = 5;
  localparam int ST_TOUT = 6;
  localparam int ST_PERR = 7;

  typedef struct packed {
    logic rd_status;
    logic rd_data;
    logic wr_cmd;
    logic wr_data;
    logic rd_miss;
  } host_sel_t;
endpackage

// File: rtl/kbc_addr_dec.sv
module kbc_addr_dec
  import kbc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit MEM_MAPPED = 1'b0,
  parameter int DATA_PORT  = 'h60,
  parameter int CMD_PORT   = 'h64,
  parameter int STAT_OFS   = 0,
  parameter int DATA_OFS   = 4
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output host_sel_t         sel
);
  localparam logic [ADDR_W-1:0] A_DATA = MEM_MAPPED ? ADDR_W'(DATA_OFS) : ADDR_W'(DATA_PORT);
  localparam logic [ADDR_W-1:0] A_STAT = MEM_MAPPED ? ADDR_W'(STAT_OFS) : ADDR_W'(CMD_PORT);

  logic hit_data, hit_stat;

  generate
    if (MEM_MAPPED) begin : g_mem
      assign hit_data = (addr == A_DATA);
      assign hit_stat = (addr == A_STAT);
    end else begin : g_port
      assign hit_data = (addr == A_DATA);
      assign hit_stat = (addr == A_STAT);
    end
  endgenerate

  always_comb begin
    sel.rd_status = cs && !we && hit_stat;
    sel.rd_data   = cs && !we && hit_data;
    sel.wr_cmd    = cs &&  we && hit_stat;
    sel.wr_data   = cs &&  we && hit_data;
    sel.rd_miss   = cs && !we && !hit_stat && !hit_data;
  end
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter int LED_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic             wr_data,
  input  logic [7:0]       wdata,
  output logic             ib_full,
  output logic             last_cmd,
  output logic             kbd_en,
  output logic             sys_flag,
  output logic [LED_W-1:0] led_q,
  output logic             selftest_req
);
  logic [7:0] ib_byte;
  logic       ib_taken;
  logic       led_pend;
  logic       take;

  assign take         = ib_full && !ib_taken;
  assign selftest_req = take && last_cmd && (ib_byte == CMD_SELFTEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_full  <= 1'b0;
      ib_taken <= 1'b0;
      ib_byte  <= '0;
      last_cmd <= 1'b0;
      kbd_en   <= 1'b0;
      sys_flag <= 1'b0;
      led_pend <= 1'b0;
      led_q    <= '0;
    end else begin
      if (ib_taken) begin
        ib_full  <= 1'b0;
        ib_taken <= 1'b0;
      end else if (take) begin
        ib_taken <= 1'b1;
        if (last_cmd) begin
          led_pend <= (ib_byte == CMD_SET_LED);
          if (ib_byte == CMD_KBD_ON)   kbd_en   <= 1'b1;
          if (ib_byte == CMD_SELFTEST) sys_flag <= 1'b1;
        end else begin
          if (led_pend) led_q <= ib_byte[LED_W-1:0];
          led_pend <= 1'b0;
        end
      end else if ((wr_cmd || wr_data) && !ib_full) begin
        ib_full  <= 1'b1;
        ib_byte  <= wdata;
        last_cmd <= wr_cmd;
      end
    end
  end

  // R5: input buffer releases one edge after the byte is consumed
  p_ibf_release_r5: assert property (@(posedge clk) disable iff (rst)
    ib_taken |=> !ib_full);
  // R5: a write while the buffer is full leaves the held byte alone
  p_busy_write_r5: assert property (@(posedge clk) disable iff (rst)
    ((wr_cmd || wr_data) && ib_full) |=> $stable(ib_byte));
  // R9: LED output moves only when a host byte was pending
  p_led_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ib_full |=> $stable(led_q));
  // R7: once enabled the keyboard stays enabled
  p_en_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    kbd_en |=> kbd_en);
endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       selftest_req,
  input  logic       dev_valid,
  input  logic [7:0] dev_code,
  input  logic       kbd_en,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] obuf,
  output logic       obf,
  output logic       timeout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      obuf    <= '0;
      obf     <= 1'b0;
      timeout <= 1'b0;
    end else begin
      if (rd_status) timeout <= 1'b0;
      if (rd_data)   obf     <= 1'b0;
      if (selftest_req) begin
        obuf <= SELFTEST_ACK;
        obf  <= 1'b1;
        if (dev_valid && kbd_en) timeout <= 1'b1;
      end else if (dev_valid && kbd_en) begin
        if (obf) begin
          timeout <= 1'b1;
        end else begin
          obuf <= dev_code;
          obf  <= 1'b1;
        end
      end
    end
  end

  // R6: self-test leaves the acknowledge byte waiting
  p_selftest_ack_r6: assert property (@(posedge clk) disable iff (rst)
    selftest_req |=> (obf && obuf == SELFTEST_ACK));
  // R8: a strobe into a full buffer flags timeout and keeps the old byte
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && kbd_en && obf && !selftest_req) |=> (timeout && $stable(obuf)));
  // R7: strobes while disabled never fill the buffer
  p_drop_off_r7: assert property (@(posedge clk) disable iff (rst)
    (dev_valid && !kbd_en && !obf && !selftest_req) |=> !obf);
  // R4: a data read empties the buffer unless a self-test refills it
  p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && obf && !selftest_req) |=> !obf);
endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
  import kbc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit MEM_MAPPED = 1'b0,
  parameter int LED_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              dev_valid,
  input  logic [7:0]        dev_code,
  output logic [LED_W-1:0]  led_state,
  output logic              obf_irq
);
  host_sel_t  sel;
  logic       ib_full, last_cmd, kbd_en, sys_flag, selftest_req;
  logic [7:0] obuf;
  logic       obf, timeout;
  logic [7:0] status;

  kbc_addr_dec #(.ADDR_W(ADDR_W), .MEM_MAPPED(MEM_MAPPED)) u_dec (
    .cs(host_cs), .we(host_we), .addr(host_addr), .sel(sel)
  );

  kbc_cmd_engine #(.LED_W(LED_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(sel.wr_cmd), .wr_data(sel.wr_data),
    .wdata(host_wdata), .ib_full(ib_full), .last_cmd(last_cmd),
    .kbd_en(kbd_en), .sys_flag(sys_flag), .led_q(led_state),
    .selftest_req(selftest_req)
  );

  kbc_out_buf u_obuf (
    .clk(clk), .rst(rst), .selftest_req(selftest_req), .dev_valid(dev_valid),
    .dev_code(dev_code), .kbd_en(kbd_en), .rd_data(sel.rd_data),
    .rd_status(sel.rd_status), .obuf(obuf), .obf(obf), .timeout(timeout)
  );

  always_comb begin
    status          = '0;
    status[ST_PERR] = 1'b0;
    status[ST_TOUT] = timeout;
    status[ST_AUX]  = 1'b0;
    status[ST_LOCK] = !kbd_en;
    status[ST_CMD]  = last_cmd;
    status[ST_SYS]  = sys_flag;
    status[ST_IBF]  = ib_full;
    status[ST_OBF]  = obf;
  end

  always_ff @(posedge clk) begin
    if (rst)                host_rdata <= '0;
    else if (sel.rd_status) host_rdata <= status;
    else if (sel.rd_data)   host_rdata <= obuf;
    else if (sel.rd_miss)   host_rdata <= '0;
  end

  assign obf_irq = obf;

  // R2: at most one register function is selected per access
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel.rd_status, sel.rd_data, sel.wr_cmd, sel.wr_data, sel.rd_miss}));
  // R2: an undecoded read returns zero
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (rst)
    sel.rd_miss |=> (host_rdata == 8'h00));
endmodule

// File: tb/kbc_regif_tb_top.sv
module kbc_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_cs, host_we;
  logic [7:0] host_addr, host_wdata;
  logic [7:0] host_rdata, mm_rdata;
  logic       dev_valid;
  logic [7:0] dev_code;
  logic [2:0] led_state, mm_led;
  logic       obf_irq, mm_irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  kbc_regif #(.ADDR_W(8), .MEM_MAPPED(1'b0), .LED_W(3)) dut_i (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_valid(dev_valid), .dev_code(dev_code), .led_state(led_state),
    .obf_irq(obf_irq)
  );

  kbc_regif #(.ADDR_W(8), .MEM_MAPPED(1'b1), .LED_W(3)) dut_mm_i (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(mm_rdata),
    .dev_valid(dev_valid), .dev_code(dev_code), .led_state(mm_led),
    .obf_irq(mm_irq)
  );

  // entry: kind[31:30] addr[29:22] data[21:14] expect[13:6] req[5:0]
  // kind 0 = host write, 1 = host read, 2 = device strobe, 3 = LED check
  localparam logic [31:0] VEC [0:27] = '{
    {2'd1, 8'h64, 8'h00, 8'h10, 6'd1},  // R1 reset status
    {2'd2, 8'h00, 8'h1C, 8'h00, 6'd7},  // R7 strobe while disabled
    {2'd1, 8'h64, 8'h00, 8'h10, 6'd7},  // R7 still empty
    {2'd0, 8'h64, 8'hAE, 8'h00, 6'd7},  // enable
    {2'd1, 8'h64, 8'h00, 8'h08, 6'd7},  // R7 lock clear, cmd flag
    {2'd2, 8'h00, 8'h1C, 8'h00, 6'd3},  // R3 strobe
    {2'd1, 8'h64, 8'h00, 8'h09, 6'd3},  // R3 OBF set
    {2'd1, 8'h60, 8'h00, 8'h1C, 6'd3},  // R3 code returned
    {2'd1, 8'h64, 8'h00, 8'h08, 6'd4},  // R4 OBF cleared
    {2'd0, 8'h64, 8'hAA, 8'h00, 6'd6},  // self-test
    {2'd1, 8'h64, 8'h00, 8'h0D, 6'd6},  // R6 sys flag + OBF
    {2'd1, 8'h60, 8'h00, 8'h55, 6'd6},  // R6 ack byte
    {2'd0, 8'h60, 8'h05, 8'h00, 6'd9},  // data without set-LEDs
    {2'd3, 8'h00, 8'h00, 8'h00, 6'd9},  // R9 LED unchanged
    {2'd0, 8'h64, 8'hED, 8'h00, 6'd9},
    {2'd0, 8'h60, 8'h06, 8'h00, 6'd9},
    {2'd3, 8'h00, 8'h00, 8'h06, 6'd9},  // R9 LED loaded
    {2'd1, 8'h64, 8'h00, 8'h04, 6'd1},  // R1 cmd flag clear after data
    {2'd0, 8'h64, 8'hED, 8'h00, 6'd9},
    {2'd0, 8'h64, 8'hAE, 8'h00, 6'd9},  // cancels pending LED
    {2'd0, 8'h60, 8'h01, 8'h00, 6'd9},
    {2'd3, 8'h00, 8'h00, 8'h06, 6'd9},  // R9 LED kept
    {2'd2, 8'h00, 8'h2A, 8'h00, 6'd8},
    {2'd2, 8'h00, 8'h3B, 8'h00, 6'd8},  // overrun
    {2'd1, 8'h64, 8'h00, 8'h45, 6'd8},  // R8 timeout set
    {2'd1, 8'h64, 8'h00, 8'h05, 6'd8},  // R8 timeout cleared by read
    {2'd1, 8'h60, 8'h00, 8'h2A, 6'd8},  // R8 first code kept
    {2'd1, 8'h20, 8'h00, 8'h00, 6'd2}   // R2 undecoded read
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0;
  endtask

  task automatic dev_send(input logic [7:0] c);
    dev_valid = 1'b1; dev_code = c;
    @(negedge clk);
    dev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; host_cs = 1'b0; host_we = 1'b0; host_addr = '0;
    host_wdata = '0; dev_valid = 1'b0; dev_code = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // reset state (R1, R10, R2)
    check({5'd0, led_state}, 8'h00, "R1 led after reset");
    check({7'd0, obf_irq}, 8'h00, "R10 irq after reset");
    host_rd(8'h00);
    check(host_rdata, 8'h00, "R2 port map offset 0 undecoded");
    check(mm_rdata, 8'h10, "R2 mem map status at offset 0");
    idle(2);

    for (int i = 0; i < 28; i++) begin
      logic [31:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[5:0], i);
      case (v[31:30])
        2'd0: host_wr(v[29:22], v[21:14]);
        2'd1: begin host_rd(v[29:22]); check(host_rdata, v[13:6], tag); end
        2'd2: dev_send(v[21:14]);
        default: check({5'd0, led_state}, v[13:6], tag);
      endcase
      idle(4);
    end

    // R5: input-buffer timing, reads capture at E1, E2, E3
    host_wr(8'h64, 8'hED);
    host_rd(8'h64); check(host_rdata, 8'h0E, "R5 IBF edge 1");
    host_rd(8'h64); check(host_rdata, 8'h0E, "R5 IBF edge 2");
    host_rd(8'h64); check(host_rdata, 8'h0C, "R5 IBF clear edge 3");
    host_wr(8'h60, 8'h07);
    idle(4);
    check({5'd0, led_state}, 8'h07, "R9 LED 7");
    // R5: second command while busy is discarded
    host_wr(8'h64, 8'hAA);
    host_wr(8'h64, 8'hED);
    idle(4);
    host_wr(8'h60, 8'h02);
    idle(4);
    check({5'd0, led_state}, 8'h07, "R5 busy write dropped");
    host_rd(8'h60); check(host_rdata, 8'h55, "R6 ack after busy");
    idle(2);

    // R10 / R4: irq follows OBF
    dev_send(8'h44);
    check({7'd0, obf_irq}, 8'h01, "R10 irq set");
    host_rd(8'h60);
    check(host_rdata, 8'h44, "R4 data byte");
    check({7'd0, obf_irq}, 8'h00, "R10 irq cleared by read");
    idle(2);

    // R2: memory-mapped instance
    host_wr(8'h00, 8'hAE);
    idle(4);
    dev_send(8'h11);
    idle(2);
    host_rd(8'h00); check(mm_rdata, 8'h09, "R2 mem map status");
    host_rd(8'h04); check(mm_rdata, 8'h11, "R2 mem map data");
    idle(2);
    finish_run();
  end
endmodule